// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex, byte-wide synchronous serial port. The block always drives the shift clock on its own clock pin. A single bidirectional data pin carries the bits in one direction at a time. Software or an upstream producer hands a byte to the port over a valid/ready write channel. The port then shifts that byte out least-significant bit first, one bit per shift-clock period, and raises a transmit-done flag at the end.

Reception is armed by a level-sensitive receive enable. It starts once that enable is high, the receive-done flag is clear and the port is idle. The port releases the data pin and loads its receive shift register with a marker pattern. It then generates eight shift-clock periods and samples the data pin on each falling edge. When the marker has been pushed out, the port publishes the byte and raises the receive-done flag.

Both flags stay set until cleared by a one-cycle clear pulse. The OR of the two flags forms one interrupt request. A mode input sets the shift-clock rate to the system clock divided by 12 or divided by 2.

On the write channel, `wr_ready` is high only while the port is idle. A beat is taken on a cycle where both `wr_valid` and `wr_ready` are high. The port never queues a beat. A producer that offers a beat while `wr_ready` is low is not served. If it keeps `wr_valid` high, its beat is taken at the first idle cycle. If it drops `wr_valid`, the beat has no effect. The receive side has no back-pressure: the byte stays on `rd_data` until the next reception completes, and `rx_flag` marks it as new.

Top module: `sync_shift_port`

## Requirements
- R1: A beat taken on the write channel (`wr_valid` and `wr_ready` high at a clock edge) starts a transmit. After that edge, `sdata_oe` is 1, `wr_ready` is 0 and `sdata_o` carries bit 0 of the byte.
- R2: Transmit bits leave least-significant first, each held for one shift-clock period. `sdata_o` changes only together with a rising edge of `sclk_o`. A receiver that samples `sdata_o` at each of the eight rising edges of `sclk_o` collects the byte.
- R3: `tx_flag` becomes 1 exactly 8*DIV clock edges after the edge that took the beat. At that same edge `sdata_oe` returns to 0 and `wr_ready` returns to 1. DIV is the division ratio in force.
- R4: A beat offered for a single cycle while a transfer is active is not taken. It does not alter the byte on the pin, and no second transmit follows.
- R5: A reception starts only when the port is idle, `rx_en` is 1 and `rx_flag` is 0. While `rx_flag` is 1, the port stays idle regardless of `rx_en`.
- R6: During reception, `sdata_oe` stays 0. `sdata_i` is sampled at each of eight falling edges of `sclk_o`, and the first sample is bit 0 of `rd_data`. `rx_flag` becomes 1, and `rd_data` updates, 8*DIV+1 clock edges after the first edge at which the arming condition holds. The extra edge loads the marker 11111110.
- R7: `fast_sel` = 0 selects DIV = 12 and `fast_sel` = 1 selects DIV = 2. `sclk_o` is low for DIV/2 cycles and then high for DIV/2 cycles in each bit period.
- R8: While idle, `sclk_o` is 1 and `sdata_oe` is 0.
- R9: Each flag holds its value until its clear input is pulsed. If a clear arrives in the same cycle as a completion, the completion wins. `irq` is 1 exactly when either flag is 1.
- R10: After reset, both flags and `irq` are 0, `wr_ready` is 1, `sclk_o` is 1 and `sdata_oe` is 0.
- R11: When a write beat and the receive-arming condition occur in the same idle cycle, the transmit is started and the reception waits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| fast_sel | input | 1 | Shift-clock rate: 0 = clock/12, 1 = clock/2 |
| rx_en | input | 1 | Receive enable level |
| wr_valid | input | 1 | Write channel valid |
| wr_ready | output | 1 | Write channel ready (port idle) |
| wr_data | input | DW | Byte to transmit |
| clr_tx | input | 1 | One-cycle clear of the transmit-done flag |
| clr_rx | input | 1 | One-cycle clear of the receive-done flag |
| tx_flag | output | 1 | Transmit done |
| rx_flag | output | 1 | Receive done |
| irq | output | 1 | Serial port interrupt request |
| rd_data | output | DW | Last received byte |
| sclk_o | output | 1 | Shift clock, idles high |
| sdata_o | output | 1 | Data pin output value |
| sdata_oe | output | 1 | Data pin output enable (1 = driving) |
| sdata_i | input | 1 | Data pin input value |

## Verification
The assertions take three things for granted about the inputs:
- `fast_sel` is held steady from the moment a transfer starts until its flag is raised.
- A write beat is offered through the valid/ready channel rather than forced onto the pin.
- `sdata_i` changes only in the half-period after a rising edge of `sclk_o`, so it never moves on a sampling edge.

The stimulus changes `fast_sel` only while the port is idle with its flags cleared. It drives every input at the falling edge of the system clock. It updates `sdata_i` right after each observed shift-clock rise, one full half-period ahead of the next falling edge.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_TX   = 2'd2,
    ST_RX   = 2'd3
  } ssp_state_e;
endpackage

// File: rtl/ssp_clkgen.sv
// Half-period prescaler and shift-clock phase. phase 0 = high half, 1 = low half.
module ssp_clkgen #(
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic sclk,
  output logic fall_stb,
  output logic rise_stb
);
  localparam int SLOW_H = SLOW_DIV / 2;
  localparam int FAST_H = FAST_DIV / 2;
  localparam int MAX_H  = (SLOW_H > FAST_H) ? SLOW_H : FAST_H;
  localparam int CW     = (MAX_H > 1) ? $clog2(MAX_H) : 1;

  logic [CW-1:0] pcnt;
  logic [CW-1:0] lim;
  logic          phase;
  logic          tick;

  assign lim  = fast ? CW'(FAST_H - 1) : CW'(SLOW_H - 1);
  assign tick = run && (pcnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pcnt  <= '0;
      phase <= 1'b0;
    end else if (tick) begin
      pcnt  <= '0;
      phase <= ~phase;
    end else begin
      pcnt  <= pcnt + CW'(1);
    end
  end

  assign sclk     = !(run && phase);
  assign fall_stb = tick && !phase;
  assign rise_stb = tick && phase;
endmodule

// File: rtl/ssp_tx_shift.sv
// Transmit shifter: LSB on the pin, advances on every shift-clock rise.
module ssp_tx_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] data,
  input  logic          rise,
  output logic          dout,
  output logic          done
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;

  logic [DW-1:0] sh;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh  <= '1;
      cnt <= '0;
    end else if (load) begin
      sh  <= data;
      cnt <= '0;
    end else if (rise) begin
      sh  <= {1'b1, sh[DW-1:1]};
      cnt <= cnt + CW'(1);
    end
  end

  assign dout = sh[0];
  assign done = rise && (cnt == CW'(DW - 1));
endmodule

// File: rtl/ssp_rx_shift.sv
// Receive shifter: preloaded with a single-zero marker; the byte is complete
// once that zero falls out of the top. Bits enter at the bottom, so the first
// sample ends at the top and the output is bit-reversed.
module ssp_rx_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          fall,
  input  logic          rise,
  input  logic          din,
  output logic [DW-1:0] rd_data,
  output logic          done
);
  localparam logic [DW-1:0] MARK = ~DW'(1);

  logic [DW-1:0] sh;
  logic [DW-1:0] rev;
  logic          gone;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= MARK;
      gone <= 1'b0;
    end else if (arm) begin
      sh   <= MARK;
      gone <= 1'b0;
    end else if (fall && !gone) begin
      sh   <= {sh[DW-2:0], din};
      gone <= !sh[DW-1];
    end
  end

  for (genvar i = 0; i < DW; i++) begin : g_rev
    assign rev[i] = sh[DW-1-i];
  end

  assign done = rise && gone;

  always_ff @(posedge clk) begin
    if (!rst_n)    rd_data <= '0;
    else if (done) rd_data <= rev;
  end
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
  parameter int DW       = 8,
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fast_sel,
  input  logic          rx_en,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          clr_tx,
  input  logic          clr_rx,
  output logic          tx_flag,
  output logic          rx_flag,
  output logic          irq,
  output logic [DW-1:0] rd_data,
  output logic          sclk_o,
  output logic          sdata_o,
  output logic          sdata_oe,
  input  logic          sdata_i
);
  import ssp_pkg::*;

  ssp_state_e state, state_nx;
  logic run, fall_stb, rise_stb, tx_load, tx_done, rx_arm, rx_done;

  assign wr_ready = (state == ST_IDLE);
  assign tx_load  = wr_ready && wr_valid;
  assign rx_arm   = (state == ST_ARM);
  assign run      = (state == ST_TX) || (state == ST_RX);
  assign sdata_oe = (state == ST_TX);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (wr_valid)                state_nx = ST_TX;
               else if (rx_en && !rx_flag) state_nx = ST_ARM;
      ST_ARM:  state_nx = ST_RX;
      ST_TX:   if (tx_done) state_nx = ST_IDLE;
      ST_RX:   if (rx_done) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  ssp_clkgen #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(run), .fast(fast_sel),
    .sclk(sclk_o), .fall_stb(fall_stb), .rise_stb(rise_stb)
  );

  ssp_tx_shift #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .data(wr_data),
    .rise(rise_stb && (state == ST_TX)), .dout(sdata_o), .done(tx_done)
  );

  ssp_rx_shift #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .arm(rx_arm),
    .fall(fall_stb && (state == ST_RX)), .rise(rise_stb && (state == ST_RX)),
    .din(sdata_i), .rd_data(rd_data), .done(rx_done)
  );

  // Completion has priority over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_flag <= 1'b0;
      rx_flag <= 1'b0;
    end else begin
      if (tx_done)     tx_flag <= 1'b1;
      else if (clr_tx) tx_flag <= 1'b0;
      if (rx_done)     rx_flag <= 1'b1;
      else if (clr_rx) rx_flag <= 1'b0;
    end
  end

  assign irq = tx_flag || rx_flag;
endmodule

// File: rtl/ssp_port_checker.sv
module ssp_port_checker (
  input logic clk,
  input logic rst_n,
  input logic fast_sel,
  input logic wr_valid,
  input logic wr_ready,
  input logic clr_tx,
  input logic clr_rx,
  input logic tx_flag,
  input logic rx_flag,
  input logic sclk_o,
  input logic sdata_o,
  input logic sdata_oe
);
  // R1: accepted beat starts a transmit
  a_r1_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (sdata_oe && !wr_ready));

  // R2: data only moves with a shift-clock rise during transmit
  a_r2_data_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata_oe && $past(sdata_oe) && !$rose(sclk_o)) |-> $stable(sdata_o));

  // R3: transmit-done coincides with releasing the pin
  a_r3_ti_releases_pin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_flag) |-> (!sdata_oe && wr_ready));

  // R4: no beat is taken while driving
  a_r4_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    sdata_oe |-> !wr_ready);

  // R5: a set receive flag blocks arming
  a_r5_no_arm_with_ri: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flag && !clr_rx && wr_ready && !wr_valid) |=> wr_ready);

  // R7: fast rate gives a one-cycle low phase
  a_r7_fast_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_o && fast_sel) |=> sclk_o);

  // R8: idle pins
  a_r8_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (sclk_o && !sdata_oe));

  // R9: flags hold without a clear
  a_r9_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flag && !clr_tx) |=> tx_flag);
  a_r9_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flag && !clr_rx) |=> rx_flag);
endmodule

bind sync_shift_port ssp_port_checker u_chk (
  .clk(clk), .rst_n(rst_n), .fast_sel(fast_sel), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .clr_tx(clr_tx), .clr_rx(clr_rx), .tx_flag(tx_flag),
  .rx_flag(rx_flag), .sclk_o(sclk_o), .sdata_o(sdata_o), .sdata_oe(sdata_oe)
);

// File: tb/tb_sync_shift_port.sv
`timescale 1ns/1ps
module tb_sync_shift_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fast_sel = 1'b0, rx_en = 1'b0, wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic clr_tx = 1'b0, clr_rx = 1'b0, sdata_i = 1'b1;
  logic wr_ready, tx_flag, rx_flag, irq, sclk_o, sdata_o, sdata_oe;
  logic [7:0] rd_data;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sync_shift_port dut (
    .clk(clk), .rst_n(rst_n), .fast_sel(fast_sel), .rx_en(rx_en),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .clr_tx(clr_tx), .clr_rx(clr_rx), .tx_flag(tx_flag), .rx_flag(rx_flag),
    .irq(irq), .rd_data(rd_data), .sclk_o(sclk_o), .sdata_o(sdata_o),
    .sdata_oe(sdata_oe), .sdata_i(sdata_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_flags();
    @(negedge clk); clr_tx = 1'b1; clr_rx = 1'b1;
    @(negedge clk); clr_tx = 1'b0; clr_rx = 1'b0;
  endtask

  // Runs one transfer from a negedge; acts as the far-end device on the pins.
  // inj >= 0 offers a one-cycle foreign beat at that cycle count.
  task automatic run_xfer(input bit is_rx, input bit fast, input logic [7:0] data,
                          input int inj, output logic [7:0] got, output int cyc);
    int k;
    bit ps, flag;
    logic pd;
    got = 8'h00; k = 0; cyc = 0; flag = 1'b0;
    fast_sel = fast;
    if (is_rx) begin sdata_i = data[0]; rx_en = 1'b1; end
    else begin wr_data = data; wr_valid = 1'b1; end
    ps = sclk_o; pd = sdata_o;
    while (!flag && cyc < 400) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      wr_valid = 1'b0;
      if (cyc == inj) begin wr_data = ~data; wr_valid = 1'b1; end
      if (!ps && sclk_o) begin
        if (!is_rx && k < 8) got[k] = pd;
        k++;
        if (is_rx && k < 8) sdata_i = data[k];
      end
      ps = sclk_o; pd = sdata_o;
      flag = is_rx ? rx_flag : tx_flag;
    end
    wr_valid = 1'b0;
    rx_en = 1'b0;
    if (is_rx) got = rd_data;
  endtask

  // {is_rx, fast, data}
  localparam logic [9:0] VEC [6] = '{
    {1'b0, 1'b0, 8'hA5},
    {1'b0, 1'b1, 8'h3C},
    {1'b0, 1'b1, 8'h01},
    {1'b1, 1'b0, 8'h96},
    {1'b1, 1'b1, 8'h80},
    {1'b1, 1'b1, 8'hFF}
  };

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] got;
    int cyc, exp_cyc;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 flags", {tx_flag, rx_flag, irq}, 3'b000);
    chk("R10 pins", {wr_ready, sclk_o, sdata_oe}, 3'b110);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[i]) begin
      run_xfer(VEC[i][9], VEC[i][8], VEC[i][7:0], -1, got, cyc);
      exp_cyc = 8 * (VEC[i][8] ? 2 : 12) + (VEC[i][9] ? 2 : 1);
      if (VEC[i][9]) begin
        chk("R6 rx byte", got, VEC[i][7:0]);
        chk("R6 R7 rx timing", cyc, exp_cyc);
      end else begin
        chk("R2 tx byte", got, VEC[i][7:0]);
        chk("R3 R7 tx timing", cyc, exp_cyc);
      end
      chk("R8 idle pins", {sclk_o, sdata_oe, wr_ready}, 3'b101);
      chk("R9 irq with flag", irq, 1'b1);
      clear_flags();
    end

    // R1: start of transmit
    @(negedge clk); fast_sel = 1'b0; wr_data = 8'h5A; wr_valid = 1'b1;
    @(negedge clk); wr_valid = 1'b0;
    chk("R1 start", {sdata_oe, wr_ready, sdata_o}, 3'b100);
    repeat (100) @(negedge clk);
    clear_flags();

    // R4: foreign beat mid-transfer ignored
    run_xfer(1'b0, 1'b0, 8'hC3, 30, got, cyc);
    chk("R4 byte unchanged", got, 8'hC3);
    repeat (20) @(negedge clk);
    chk("R4 no second tx", {sdata_oe, wr_ready}, 2'b01);

    // R9: flag holds, clear one at a time
    repeat (30) @(negedge clk);
    chk("R9 tx hold", {tx_flag, irq}, 2'b11);
    clr_tx = 1'b1; @(negedge clk); clr_tx = 1'b0;
    chk("R9 tx cleared", {tx_flag, irq}, 2'b00);

    // R5: set receive flag blocks arming
    run_xfer(1'b1, 1'b1, 8'h6B, -1, got, cyc);
    @(negedge clk); rx_en = 1'b1;
    repeat (30) @(negedge clk);
    chk("R5 blocked by flag", {wr_ready, sclk_o, rx_flag}, 3'b111);
    clr_rx = 1'b1; @(negedge clk); clr_rx = 1'b0;
    @(negedge clk);
    chk("R5 arms after clear", wr_ready, 1'b0);
    chk("R6 pin released", sdata_oe, 1'b0);
    rx_en = 1'b0;
    repeat (40) @(negedge clk);
    clear_flags();

    // R11: write and arm together -> transmit first
    @(negedge clk); fast_sel = 1'b1; rx_en = 1'b1; wr_data = 8'h77; wr_valid = 1'b1;
    @(negedge clk); wr_valid = 1'b0;
    chk("R11 tx wins", sdata_oe, 1'b1);
    rx_en = 1'b0;
    repeat (40) @(negedge clk);
    chk("R11 tx done", tx_flag, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule